// File: doc/BRIEF.md
# Supply and Push-button Reset Generator

This block drives the system reset of a processor-based design. It watches two digital "supply is low" flags from external comparators at different trip levels, a manual push-button input, and a one-cycle timeout request from a watchdog. Any of these causes forces reset active. Reset then stays active for a fixed hold interval after the last cause clears, so the supply and the processor have time to settle.

A tolerance-select strap picks which of the two comparator flags counts as a power failure. The other flag is ignored. While a supply fault is present, the hold count keeps restarting, so a new dip during the hold extends the reset. The push-button is debounced against a 1 ms tick derived from the clock frequency parameter. It must be seen low for a set delay before reset asserts, so short glitches are rejected. After the button is released, reset stays active for the full hold interval.

All asynchronous inputs pass through two-flop synchronizers before use. The block has an active-high reset output and an active-low reset output, and the two are always complementary. The block's own power-on clear leaves reset active and starts a hold interval.

Top module: `supply_reset_gen`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1. After `rst_n` rises, `sys_rst` stays 1 for at least `HOLD_MS` ms and falls within one further ms plus a few cycles.
- R2: With `tol_sel` = 0, a high level on `sup_low_475` asserts `sys_rst` within 4 clock cycles. A high level on `sup_low_450` has no effect on `sys_rst`.
- R3: With `tol_sel` = 1, a high level on `sup_low_450` asserts `sys_rst` within 4 clock cycles. A high level on `sup_low_475` has no effect on `sys_rst`.
- R4: After the selected supply flag returns low, `sys_rst` stays 1 for at least `HOLD_MS` ms. It falls within one further ms plus a few cycles. A new dip during the hold restarts the interval from the new dip's end.
- R5: A low pulse on `pb_n` lasting at most `PB_DELAY_MS`-2 ms never asserts `sys_rst`. This includes any pulse shorter than 1 ms.
- R6: `pb_n` held low for at least `PB_DELAY_MS`+1 ms asserts `sys_rst` before the pulse ends. With the default delay of 10 ms, every pulse of 20 ms or longer is recognized.
- R7: After `pb_n` returns high from a recognized press, `sys_rst` stays 1 for at least `HOLD_MS` ms. It falls within one further ms plus a few cycles.
- R8: A one-cycle high on `wdt_req` makes `sys_rst` 1 from the next clock edge. It then holds for at least `HOLD_MS` ms.
- R9: `sys_rst_n` is always the inverse of `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of frequency `CLK_HZ` |
| rst_n | input | 1 | Synchronous active-low power-on clear of the block |
| tol_sel | input | 1 | Tolerance strap: 0 selects the 4.75 V flag, 1 selects the 4.5 V flag |
| sup_low_475 | input | 1 | Asynchronous flag, high when supply is below 4.75 V |
| sup_low_450 | input | 1 | Asynchronous flag, high when supply is below 4.5 V |
| pb_n | input | 1 | Asynchronous push-button, low when pressed |
| wdt_req | input | 1 | Synchronous one-cycle timeout request from a watchdog |
| sys_rst | output | 1 | Active-high system reset |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The bench sends long levels on the unselected comparator flag under both strap settings. A wrong multiplexer would reset there. It also inserts a second dip midway through a supply hold, which catches a design that times the hold from the first dip and releases about a thousand cycles early. Push-button pulses are drawn from both sides of an ambiguous band around the delay, including a sub-millisecond glitch. A debounce that counts ticks wrongly either resets on a glitch or misses a long press. Every release time is bracketed from both sides, so an off-by-one-tick hold, a missing extra tick, or a stuck counter shows up as an early or late fall.

// File: rtl/rstgen_pkg.sv
// Shared types for the supply and push-button reset generator.
// Assumes: nothing beyond standard SystemVerilog.
package rstgen_pkg;

    // Raw asynchronous inputs, grouped so one synchronizer bank carries them.
    typedef struct packed {
        logic sup_a;   // supply below upper threshold
        logic sup_b;   // supply below lower threshold
        logic pb_n;    // push-button, low = pressed
        logic tol;     // tolerance strap
    } async_in_t;

    // Reset value of the synchronized bank: button released, no faults.
    localparam async_in_t ASYNC_IDLE = '{sup_a: 1'b0, sup_b: 1'b0, pb_n: 1'b1, tol: 1'b0};

endpackage

// File: rtl/rg_sync.sv
// Two-flop synchronizer bank, one chain per bit.
// Assumes: each bit is an independent level; per-bit reset values given by RST_VAL.
module rg_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= RST_VAL[i];
                q[i] <= RST_VAL[i];
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/rg_tick.sv
// Free-running divider giving a one-cycle pulse every CYC clock cycles.
// Assumes: CYC >= 1; the first pulse comes CYC cycles after reset.
module rg_tick #(
    parameter int CYC = 125_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(CYC - 1);

    logic [TW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Wrap-around cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rg_pb_filter.sv
// Push-button debounce: the press is recognized after DELAY ticks of continuous low.
// Assumes: pb_n_s is already synchronized; any high sample cancels the count.
module rg_pb_filter #(
    parameter int DELAY = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pb_n_s,
    output logic pressed
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt;

    // Count ticks while held low; set pressed on reaching the delay.
    always_ff @(posedge clk) begin
        if (!rst_n || pb_n_s) begin
            cnt     <= '0;
            pressed <= 1'b0;
        end else if (tick && !pressed) begin
            if (cnt == LAST) pressed <= 1'b1;
            else             cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rg_hold.sv
// Reset stretcher: active while restart is high, then for HOLD+1 more ticks.
// Assumes: restart is synchronous; power-on clear leaves active set.
module rg_hold #(
    parameter int HOLD = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic active
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD);

    logic [CW-1:0] cnt;

    // Restart on any cause, release after the tick count passes HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (active && tick) begin
            if (cnt == LAST) active <= 1'b0;
            else             cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/supply_reset_gen.sv
// Top of the reset generator: synchronizes causes, selects the supply flag by
// the tolerance strap, debounces the button and stretches reset by HOLD_MS.
// Assumes: CLK_HZ is a multiple of 1000; wdt_req is synchronous to clk.
module supply_reset_gen
    import rstgen_pkg::*;
#(
    parameter int CLK_HZ      = 125_000_000,
    parameter int HOLD_MS     = 250,
    parameter int PB_DELAY_MS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tol_sel,
    input  logic sup_low_475,
    input  logic sup_low_450,
    input  logic pb_n,
    input  logic wdt_req,
    output logic sys_rst,
    output logic sys_rst_n
);
    localparam int CYC_PER_MS = CLK_HZ / 1000;

    async_in_t raw, syn;
    logic      tick;
    logic      fault_sel;
    logic      pb_pressed;
    logic      restart;
    logic      active;

    assign raw = '{sup_a: sup_low_475, sup_b: sup_low_450, pb_n: pb_n, tol: tol_sel};

    rg_sync #(.W($bits(async_in_t)), .RST_VAL(ASYNC_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    rg_tick #(.CYC(CYC_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    rg_pb_filter #(.DELAY(PB_DELAY_MS)) u_pb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pb_n_s(syn.pb_n), .pressed(pb_pressed)
    );

    // Strap chooses which comparator flag is a power failure.
    assign fault_sel = syn.tol ? syn.sup_b : syn.sup_a;
    assign restart   = fault_sel | pb_pressed | wdt_req;

    rg_hold #(.HOLD(HOLD_MS)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .active(active)
    );

    assign sys_rst   = active;
    assign sys_rst_n = ~active;
endmodule

// File: rtl/supply_reset_gen_chk.sv
// Property checker bound to the reset generator.
// Assumes: HOLD_CYC is the hold interval in clock cycles.
module supply_reset_gen_chk #(
    parameter int HOLD_CYC = 250
) (
    input logic clk,
    input logic rst_n,
    input logic fault,
    input logic pb_pressed,
    input logic wdt_req,
    input logic sys_rst
);
    logic [31:0] since_cause;

    // Cycles since the last reset cause, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || fault || pb_pressed || wdt_req) since_cause <= '0;
        else if (since_cause != 32'hFFFF_FFFF)        since_cause <= since_cause + 1;
    end

    AST_FAULT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n) fault |=> sys_rst); // R2
    AST_PB_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n) pb_pressed |=> sys_rst); // R6
    AST_WDT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n) wdt_req |=> sys_rst); // R8
    AST_HOLD_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n) $fell(sys_rst) |-> since_cause >= 32'(HOLD_CYC)); // R4
    AST_PB_RELEASE_HELD: assert property (@(posedge clk) disable iff (!rst_n) $fell(pb_pressed) |-> sys_rst); // R7
endmodule

bind supply_reset_gen supply_reset_gen_chk #(.HOLD_CYC(HOLD_MS * CYC_PER_MS)) u_chk (
    .clk(clk), .rst_n(rst_n), .fault(fault_sel), .pb_pressed(pb_pressed),
    .wdt_req(wdt_req), .sys_rst(sys_rst)
);

// File: tb/supply_reset_gen_test.sv
// Self-checking bench: directed corners plus seeded random causes.
module supply_reset_gen_test;
    localparam int CYC  = 8;
    localparam int HOLD = 250;
    localparam int PBD  = 10;
    localparam int HCYC = HOLD * CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tol_sel = 1'b0;
    logic sup_low_475 = 1'b0;
    logic sup_low_450 = 1'b0;
    logic pb_n = 1'b1;
    logic wdt_req = 1'b0;
    logic sys_rst, sys_rst_n;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    supply_reset_gen #(.CLK_HZ(CYC * 1000), .HOLD_MS(HOLD), .PB_DELAY_MS(PBD)) uut (
        .clk(clk), .rst_n(rst_n), .tol_sel(tol_sel), .sup_low_475(sup_low_475),
        .sup_low_450(sup_low_450), .pb_n(pb_n), .wdt_req(wdt_req),
        .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
    );

    function automatic bit exp_pb(int ms);
        return ms >= PBD + 1;
    endfunction

    function automatic bit exp_flag(bit which, bit tol);
        return which == tol;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_out(int exp, string req);
        chk(sys_rst == exp[0], req, int'(sys_rst), exp);
        chk(sys_rst_n == !exp[0], "R9", int'(sys_rst_n), int'(!exp[0]));
    endtask

    // Called right after the cause is removed at the input.
    task automatic check_hold(string req);
        step(HCYC - 2);
        check_out(1, req);
        step(CYC + 10);
        check_out(0, req);
    endtask

    task automatic pb_case(int len_cyc, bit exp);
        bit seen = 1'b0;
        pb_n = 1'b0;
        repeat (len_cyc) begin
            step(1);
            if (sys_rst) seen = 1'b1;
        end
        pb_n = 1'b1;
        if (exp) begin
            chk(seen, "R6", int'(seen), 1);
            check_hold("R7");
        end else begin
            chk(!seen, "R5", int'(seen), 0);
            step(20);
            check_out(0, "R5");
        end
    endtask

    task automatic flag_case(bit which, bit tol, int len);
        bit seen = 1'b0;
        bit exp = exp_flag(which, tol);
        string req = tol ? "R3" : "R2";
        tol_sel = tol;
        step(4);
        if (which) sup_low_450 = 1'b1; else sup_low_475 = 1'b1;
        repeat (len) begin
            step(1);
            if (sys_rst) seen = 1'b1;
        end
        sup_low_450 = 1'b0;
        sup_low_475 = 1'b0;
        chk(seen == exp, req, int'(seen), int'(exp));
        if (exp) check_hold("R4");
        else begin
            step(20);
            check_out(0, req);
        end
    endtask

    task automatic wdt_case();
        wdt_req = 1'b1;
        step(1);
        wdt_req = 1'b0;
        check_out(1, "R8");
        step(HCYC - 4);
        check_out(1, "R8");
        step(CYC + 8);
        check_out(0, "R8");
    endtask

    initial begin
        step(1);
        check_out(1, "R1");
        step(5);
        check_out(1, "R1");
        rst_n = 1'b1;
        check_hold("R1");

        // R2 / R3: unselected flag ignored, selected flag asserts.
        flag_case(1'b1, 1'b0, 150);
        flag_case(1'b0, 1'b0, 40);
        flag_case(1'b0, 1'b1, 150);
        flag_case(1'b1, 1'b1, 40);

        // R4: second dip during the hold restarts it.
        tol_sel = 1'b0;
        step(4);
        sup_low_475 = 1'b1;
        step(50);
        sup_low_475 = 1'b0;
        step(1000);
        check_out(1, "R4");
        sup_low_475 = 1'b1;
        step(10);
        sup_low_475 = 1'b0;
        check_hold("R4");

        // R5: sub-millisecond glitch and a short press.
        pb_case(CYC / 2, 1'b0);
        pb_case((PBD - 2) * CYC, 1'b0);
        // R6 / R7: long press.
        pb_case(20 * CYC, 1'b1);

        // R8: watchdog request.
        wdt_case();

        // Random mix.
        void'($urandom(32'h5EED_0001));
        for (int i = 0; i < 14; i++) begin
            int kind = int'($urandom_range(0, 3));
            case (kind)
                0: begin
                    int ms = int'($urandom_range(1, PBD - 2));
                    pb_case(ms * CYC, exp_pb(ms));
                end
                1: begin
                    int ms = int'($urandom_range(PBD + 2, 25));
                    pb_case(ms * CYC, exp_pb(ms));
                end
                2: flag_case(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                             int'($urandom_range(8, 200)));
                default: wdt_case();
            endcase
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule